// File: doc/BRIEF.md
# Receive Output Mode and Edge Selector

This block is the per-channel receive output stage of a four-channel T1/E1 line receiver. For each channel it decides what reaches the receive data pins and the receive clock pin. In recovery mode these are retimed data from the clock and data recovery circuit together with its recovered clock. In bypass mode they are the raw positive and negative slicer pulses, and the receive clock is the XOR of those two pulses, which lets an external circuit recover the clock.

A 4-bit mode register holds one bypass bit per channel. A global force input puts every channel into bypass and overrides that register. A single edge-select input does two jobs:
- In recovery mode it picks which edge of the recovered clock launches the receive data, and which edge of the serial clock launches the serial control output.
- In bypass mode it sets the polarity of the raw slicer outputs.

The serial input and the transmit data inputs are always active high and are always sampled on fixed edges. The edge-select input does not change them.

All logic runs in one fast system clock domain. The recovered clock, the serial clock and the transmit clocks arrive as sampled levels, and their edges are found by comparing each level with its value one cycle earlier. Every output is a register.

A change of mode waits until the new clock source has the same level as the present receive clock output. The switch therefore never adds an edge or a short pulse to the receive clock.

Top module: `rxo_mode_sel`

## Requirements
- R1: With a channel's active mode at recovery (mode_active bit 0), rx_clk_o follows rec_clk one system clock later. rx_p and rx_n change only in the cycle after a launch edge of rec_clk, and at other times they hold their value.
- R2: In recovery mode, a launch edge loads rx_p/rx_n as follows. With single_rail at 0 it loads rec_pos/rec_neg (dual-rail retimed data). With single_rail at 1 it loads rec_dec/rec_cv (decoded data and code-violation flag).
- R3: With a channel's active mode at bypass (mode_active bit 1), rx_p and rx_n carry the raw slicer pulses raw_pos and raw_neg, registered once. rx_clk_o carries the registered value of raw_pos XOR raw_neg.
- R4: While force_raw is 1, every channel is driven toward bypass whatever its mode register bit. Once bypass is active, it stays active for as long as force_raw stays 1.
- R5: In recovery mode, the launch edge of rec_clk is the rising edge when edge_sel is 1 and the falling edge when edge_sel is 0.
- R6: In bypass mode, edge_sel sets the raw output polarity. With edge_sel at 1 the outputs are active high (raw value as received). With edge_sel at 0 they are active low (inverted).
- R7: ser_out loads ser_out_d in the cycle after a falling edge of sclk when edge_sel is 1, and after a rising edge of sclk when edge_sel is 0.
- R8: ser_in_q loads ser_in in the cycle after a rising edge of sclk, whatever edge_sel says.
- R9: tx_pos_q and tx_neg_q load the active-high tx_pos and tx_neg of each channel in the cycle after a falling edge of that channel's tclk, whatever edge_sel says.
- R10: Bit n of the mode register written through mode_we/mode_wdata, OR force_raw, gives the wanted mode of channel n. The active mode takes the wanted value only in a cycle where the new source level equals the present rx_clk_o. In that cycle rx_clk_o keeps its value. The new source level is raw_pos XOR raw_neg for bypass and rec_clk for recovery.
- R11: In a cycle with rst_n low, the following are all cleared to 0 at the clock edge: the mode register, the active modes, every data and clock output, ser_out, ser_in_q and the transmit capture registers. Edge history always loads the present input levels, so no edge is seen on the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_we | input | 1 | Write strobe for the per-channel bypass register |
| mode_wdata | input | N | Bypass bits, one per channel (1 = bypass) |
| force_raw | input | 1 | Global force of bypass mode on all channels |
| edge_sel | input | 1 | Launch-edge select, and raw polarity in bypass |
| single_rail | input | 1 | 1 selects decoded single-rail data in recovery mode |
| raw_pos | input | N | Raw positive slicer pulses, active high |
| raw_neg | input | N | Raw negative slicer pulses, active high |
| rec_clk | input | N | Recovered clock levels |
| rec_pos | input | N | Retimed positive-rail data |
| rec_neg | input | N | Retimed negative-rail data |
| rec_dec | input | N | Decoded single-rail data |
| rec_cv | input | N | Code-violation flag for single rail |
| sclk | input | 1 | Serial control clock level |
| ser_out_d | input | 1 | Next serial output bit |
| ser_in | input | 1 | Serial input data |
| tclk | input | N | Transmit clock levels |
| tx_pos | input | N | Transmit positive data |
| tx_neg | input | N | Transmit negative data |
| rx_p | output | N | Receive data / positive rail output |
| rx_n | output | N | Receive negative rail / violation output |
| rx_clk_o | output | N | Receive clock output |
| mode_active | output | N | Active mode per channel (1 = bypass) |
| ser_out | output | 1 | Launched serial output |
| ser_in_q | output | 1 | Captured serial input |
| tx_pos_q | output | N | Captured transmit positive data |
| tx_neg_q | output | N | Captured transmit negative data |

## Verification
Every output is one register away from the inputs. A result is therefore due at the first system clock edge after the inputs that cause it, and edges are judged against the levels of the previous cycle. The mode switch of R10 is the one exception: it can wait any number of cycles until the clock levels agree, and the bench's own model tracks that wait.

The driver sets the inputs at a falling edge and works out the expected outputs for the next rising edge from its model. It then queues that expectation. The monitor pops and compares one item 1 ns after each rising edge, so each comparison reads exactly the cycle in which the result is due.

// File: rtl/rxo_pkg.sv
// Shared types and helpers for the receive output mode selector.
// Assumes single-bit channel slices; widths are set by the users.
package rxo_pkg;

    // Source of a channel's receive outputs.
    typedef enum logic {
        SRC_REC = 1'b0,
        SRC_RAW = 1'b1
    } src_e;

    // Apply output polarity: active_high=1 passes, 0 inverts.
    function automatic logic pol_apply(input logic v, input logic active_high);
        return active_high ? v : ~v;
    endfunction

endpackage

// File: rtl/rxo_edge_det.sv
// Edge finder for sampled clock levels.
// Keeps last cycle's level of each bit and flags a rising (rise_sel=1)
// or falling (rise_sel=0) transition. History always loads the present
// level, so after reset no stale edge appears. Assumes inputs are
// synchronous to clk.
module rxo_edge_det #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic [W-1:0] sig,
    input  logic         rise_sel,
    output logic [W-1:0] evt
);

    logic [W-1:0] prev;

    // Record the level seen this cycle.
    always_ff @(posedge clk) begin
        prev <= sig;
    end

    // Compare present and previous levels in the chosen direction.
    always_comb begin
        evt = rise_sel ? (sig & ~prev) : (~sig & prev);
    end

endmodule

// File: rtl/rxo_chan.sv
// One receive channel output slice.
// Chooses between retimed recovered data and raw slicer pulses, forms the
// receive clock output, and moves the active mode only when the new
// clock source level equals the present clock output (no extra edge).
// Assumes launch is a one-cycle flag for the chosen recovered clock edge.
module rxo_chan
    import rxo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic want_raw,
    input  logic edge_sel,
    input  logic single_rail,
    input  logic raw_pos,
    input  logic raw_neg,
    input  logic rec_clk,
    input  logic rec_pos,
    input  logic rec_neg,
    input  logic rec_dec,
    input  logic rec_cv,
    input  logic launch,
    output logic rx_p,
    output logic rx_n,
    output logic rx_clk_o,
    output logic raw_active
);

    src_e act_q;
    src_e act_nx;
    src_e want_src;
    logic raw_clk;
    logic cand_clk;
    logic clk_nx;
    logic rec_p_sel;
    logic rec_n_sel;

    // Wanted source and the clock level it would produce.
    always_comb begin
        want_src = want_raw ? SRC_RAW : SRC_REC;
        raw_clk  = raw_pos ^ raw_neg;
        cand_clk = (want_src == SRC_RAW) ? raw_clk : rec_clk;
    end

    // Switch only when the new source level matches the clock output.
    always_comb begin
        act_nx = act_q;
        if ((want_src != act_q) && (cand_clk == rx_clk_o)) begin
            act_nx = want_src;
        end
        clk_nx = (act_nx == SRC_RAW) ? raw_clk : rec_clk;
    end

    // Retimed data pick for dual or single rail.
    always_comb begin
        rec_p_sel = single_rail ? rec_dec : rec_pos;
        rec_n_sel = single_rail ? rec_cv  : rec_neg;
    end

    // Mode and clock output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q    <= SRC_REC;
            rx_clk_o <= 1'b0;
        end else begin
            act_q    <= act_nx;
            rx_clk_o <= clk_nx;
        end
    end

    // Data output registers: raw with polarity, or retimed on launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_p <= 1'b0;
            rx_n <= 1'b0;
        end else if (act_nx == SRC_RAW) begin
            rx_p <= pol_apply(raw_pos, edge_sel);
            rx_n <= pol_apply(raw_neg, edge_sel);
        end else if (launch) begin
            rx_p <= rec_p_sel;
            rx_n <= rec_n_sel;
        end
    end

    // Expose the active mode.
    always_comb begin
        raw_active = (act_q == SRC_RAW);
    end

endmodule

// File: rtl/rxo_ctl_port.sv
// Serial control output launch, serial input capture and transmit capture.
// Serial output launches on the sclk edge picked by edge_sel; serial input
// is sampled on rising sclk; transmit data is sampled on falling tclk.
// Assumes all clocks arrive as levels synchronous to clk.
module rxo_ctl_port #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         edge_sel,
    input  logic         sclk,
    input  logic         ser_out_d,
    input  logic         ser_in,
    input  logic [N-1:0] tclk,
    input  logic [N-1:0] tx_pos,
    input  logic [N-1:0] tx_neg,
    output logic         ser_out,
    output logic         ser_in_q,
    output logic [N-1:0] tx_pos_q,
    output logic [N-1:0] tx_neg_q
);

    logic s_launch;
    logic s_rise;
    logic [N-1:0] t_fall;

    rxo_edge_det #(.W(1)) u_s_launch (
        .clk(clk), .sig(sclk), .rise_sel(~edge_sel), .evt(s_launch)
    );

    rxo_edge_det #(.W(1)) u_s_rise (
        .clk(clk), .sig(sclk), .rise_sel(1'b1), .evt(s_rise)
    );

    rxo_edge_det #(.W(N)) u_t_fall (
        .clk(clk), .sig(tclk), .rise_sel(1'b0), .evt(t_fall)
    );

    // Serial output launch and serial input capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_out  <= 1'b0;
            ser_in_q <= 1'b0;
        end else begin
            if (s_launch) ser_out  <= ser_out_d;
            if (s_rise)   ser_in_q <= ser_in;
        end
    end

    // Per-channel transmit capture on falling tclk.
    for (genvar g = 0; g < N; g++) begin : g_tx
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tx_pos_q[g] <= 1'b0;
                tx_neg_q[g] <= 1'b0;
            end else if (t_fall[g]) begin
                tx_pos_q[g] <= tx_pos[g];
                tx_neg_q[g] <= tx_neg[g];
            end
        end
    end

endmodule

// File: rtl/rxo_mode_sel.sv
// Top of the receive output mode and edge selector.
// Holds the per-channel bypass register, merges the global force input,
// finds recovered clock launch edges and instantiates one slice per
// channel plus the serial/transmit port. Assumes all inputs are
// synchronous to clk; reset is synchronous, active low.
module rxo_mode_sel #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_we,
    input  logic [N-1:0] mode_wdata,
    input  logic         force_raw,
    input  logic         edge_sel,
    input  logic         single_rail,
    input  logic [N-1:0] raw_pos,
    input  logic [N-1:0] raw_neg,
    input  logic [N-1:0] rec_clk,
    input  logic [N-1:0] rec_pos,
    input  logic [N-1:0] rec_neg,
    input  logic [N-1:0] rec_dec,
    input  logic [N-1:0] rec_cv,
    input  logic         sclk,
    input  logic         ser_out_d,
    input  logic         ser_in,
    input  logic [N-1:0] tclk,
    input  logic [N-1:0] tx_pos,
    input  logic [N-1:0] tx_neg,
    output logic [N-1:0] rx_p,
    output logic [N-1:0] rx_n,
    output logic [N-1:0] rx_clk_o,
    output logic [N-1:0] mode_active,
    output logic         ser_out,
    output logic         ser_in_q,
    output logic [N-1:0] tx_pos_q,
    output logic [N-1:0] tx_neg_q
);

    logic [N-1:0] mode_q;
    logic [N-1:0] want_raw;
    logic [N-1:0] launch;

    // Per-channel bypass register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (mode_we) begin
            mode_q <= mode_wdata;
        end
    end

    // Global force overrides the register.
    always_comb begin
        want_raw = mode_q | {N{force_raw}};
    end

    rxo_edge_det #(.W(N)) u_rec_edge (
        .clk(clk), .sig(rec_clk), .rise_sel(edge_sel), .evt(launch)
    );

    for (genvar g = 0; g < N; g++) begin : g_ch
        rxo_chan u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .want_raw   (want_raw[g]),
            .edge_sel   (edge_sel),
            .single_rail(single_rail),
            .raw_pos    (raw_pos[g]),
            .raw_neg    (raw_neg[g]),
            .rec_clk    (rec_clk[g]),
            .rec_pos    (rec_pos[g]),
            .rec_neg    (rec_neg[g]),
            .rec_dec    (rec_dec[g]),
            .rec_cv     (rec_cv[g]),
            .launch     (launch[g]),
            .rx_p       (rx_p[g]),
            .rx_n       (rx_n[g]),
            .rx_clk_o   (rx_clk_o[g]),
            .raw_active (mode_active[g])
        );
    end

    rxo_ctl_port #(.N(N)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_sel (edge_sel),
        .sclk     (sclk),
        .ser_out_d(ser_out_d),
        .ser_in   (ser_in),
        .tclk     (tclk),
        .tx_pos   (tx_pos),
        .tx_neg   (tx_neg),
        .ser_out  (ser_out),
        .ser_in_q (ser_in_q),
        .tx_pos_q (tx_pos_q),
        .tx_neg_q (tx_neg_q)
    );

endmodule

// File: rtl/rxo_mode_sel_chk.sv
// Checker for rxo_mode_sel, attached with bind below.
// Relates the clock output and active mode to past inputs.
module rxo_mode_sel_chk #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         force_raw,
    input logic [N-1:0] raw_pos,
    input logic [N-1:0] raw_neg,
    input logic [N-1:0] rec_clk,
    input logic [N-1:0] rx_clk_o,
    input logic [N-1:0] mode_active
);

    for (genvar g = 0; g < N; g++) begin : g_chk
        AST_RAW_CLK_XOR: assert property (@(posedge clk) disable iff (!rst_n)
            mode_active[g] |-> rx_clk_o[g] == $past(raw_pos[g] ^ raw_neg[g])); // R3
        AST_REC_CLK_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
            !mode_active[g] |-> rx_clk_o[g] == $past(rec_clk[g])); // R1
        AST_FORCE_HOLDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(force_raw) && $past(mode_active[g])) |-> mode_active[g]); // R4
        AST_SWITCH_IN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(mode_active[g]) |-> rx_clk_o[g] == $past(rx_clk_o[g])); // R10
        AST_SWITCH_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(mode_active[g]) |-> rx_clk_o[g] == $past(rx_clk_o[g])); // R10
    end

endmodule

bind rxo_mode_sel rxo_mode_sel_chk #(.N(N)) u_chk (.*);

// File: tb/rxo_mode_sel_bench.sv
`timescale 1ns/1ps
module rxo_mode_sel_bench;

    localparam int N = 4;
    localparam int VW = 6 * N + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_we = 1'b0;
    logic [N-1:0] mode_wdata = '0;
    logic force_raw = 1'b0, edge_sel = 1'b1, single_rail = 1'b0;
    logic [N-1:0] raw_pos = '0, raw_neg = '0, rec_clk = '0, rec_pos = '0;
    logic [N-1:0] rec_neg = '0, rec_dec = '0, rec_cv = '0;
    logic sclk = 1'b0, ser_out_d = 1'b0, ser_in = 1'b0;
    logic [N-1:0] tclk = '0, tx_pos = '0, tx_neg = '0;
    logic [N-1:0] rx_p, rx_n, rx_clk_o, mode_active, tx_pos_q, tx_neg_q;
    logic ser_out, ser_in_q;

    always #2 clk = ~clk;

    rxo_mode_sel #(.N(N)) u_rxo_mode_sel (.*);

    typedef struct {
        logic [VW-1:0] val;
        string tag;
    } exp_t;
    exp_t q[$];

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // bench model state
    logic [N-1:0] m_mode = '0, m_act = '0, m_p = '0, m_n = '0, m_ck = '0;
    logic [N-1:0] m_txp = '0, m_txn = '0;
    logic m_so = 1'b0, m_si = 1'b0;
    logic [N-1:0] p_rec = '0, p_tclk = '0;
    logic p_sclk = 1'b0;

    // driver: predict the next edge's outputs, queue them, move to next negedge
    task automatic tick(input string tag);
        exp_t e;
        logic [N-1:0] launch;
        logic s_r, s_f;
        launch = edge_sel ? (rec_clk & ~p_rec) : (~rec_clk & p_rec);
        s_r = sclk & ~p_sclk;
        s_f = ~sclk & p_sclk;
        if (!rst_n) begin
            m_mode = '0; m_act = '0; m_p = '0; m_n = '0; m_ck = '0;
            m_txp = '0; m_txn = '0; m_so = 1'b0; m_si = 1'b0;
        end else begin
            for (int i = 0; i < N; i++) begin
                logic want, rawc, cand, an;
                want = force_raw | m_mode[i];
                rawc = raw_pos[i] ^ raw_neg[i];
                cand = want ? rawc : rec_clk[i];
                an = (want != m_act[i] && cand == m_ck[i]) ? want : m_act[i];
                m_ck[i] = an ? rawc : rec_clk[i];
                if (an) begin
                    m_p[i] = edge_sel ? raw_pos[i] : ~raw_pos[i];
                    m_n[i] = edge_sel ? raw_neg[i] : ~raw_neg[i];
                end else if (launch[i]) begin
                    m_p[i] = single_rail ? rec_dec[i] : rec_pos[i];
                    m_n[i] = single_rail ? rec_cv[i] : rec_neg[i];
                end
                m_act[i] = an;
                if (~tclk[i] & p_tclk[i]) begin
                    m_txp[i] = tx_pos[i];
                    m_txn[i] = tx_neg[i];
                end
            end
            if (edge_sel ? s_f : s_r) m_so = ser_out_d;
            if (s_r) m_si = ser_in;
            if (mode_we) m_mode = mode_wdata;
        end
        p_rec = rec_clk; p_sclk = sclk; p_tclk = tclk;
        e.val = {m_p, m_n, m_ck, m_act, m_so, m_si, m_txp, m_txn};
        e.tag = tag;
        q.push_back(e);
        @(negedge clk);
    endtask

    // monitor: compare one queued item just after each rising edge
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            logic [VW-1:0] act;
            e = q.pop_front();
            act = {rx_p, rx_n, rx_clk_o, mode_active, ser_out, ser_in_q, tx_pos_q, tx_neg_q};
            checks++;
            if (act !== e.val) begin
                fails++;
                $display("FAIL %s actual=%h expected=%h", e.tag, act, e.val);
            end
        end
    end

    task automatic rec_loop(input string tag);
        for (int k = 0; k < 12; k++) begin
            rec_clk = ((k >> 1) & 1) ? '1 : '0;
            rec_clk[3] = ~rec_clk[3];
            rec_pos = 4'(k * 5);
            rec_neg = 4'(k * 3 + 1);
            rec_dec = 4'(k * 7 + 2);
            rec_cv = 4'(k * 9);
            tick(tag);
        end
    endtask

    task automatic raw_loop(input string tag);
        for (int k = 0; k < 12; k++) begin
            raw_pos = 4'(k * 7);
            raw_neg = 4'(k * 11) & ~raw_pos;
            rec_clk = (k & 1) ? '1 : '0;
            tick(tag);
        end
    endtask

    initial begin
        @(negedge clk);
        tick("R11"); tick("R11"); tick("R11");
        rst_n = 1'b1;
        edge_sel = 1'b1;
        rec_loop("R1");
        edge_sel = 1'b0;
        rec_loop("R5");
        single_rail = 1'b1;
        rec_loop("R2");
        single_rail = 1'b0;
        edge_sel = 1'b1;
        rec_clk = '1; raw_pos = '0; raw_neg = '0;
        tick("R10");
        mode_we = 1'b1; mode_wdata = 4'b0101;
        tick("R10");
        mode_we = 1'b0;
        tick("R10"); tick("R10");
        rec_clk = '0;
        tick("R10"); tick("R10"); tick("R10");
        raw_loop("R3");
        edge_sel = 1'b0;
        raw_loop("R6");
        edge_sel = 1'b1;
        force_raw = 1'b1;
        raw_loop("R4");
        force_raw = 1'b0;
        raw_loop("R4");
        mode_we = 1'b1; mode_wdata = '0;
        tick("R10");
        mode_we = 1'b0;
        raw_loop("R10");
        rec_loop("R10");
        for (int s = 0; s < 3; s++) begin
            edge_sel = (s == 1) ? 1'b0 : 1'b1;
            for (int k = 0; k < 16; k++) begin
                sclk = k[1];
                ser_out_d = k[0] ^ k[2];
                ser_in = k[0] ^ k[3];
                tclk = {N{k[1]}} ^ 4'(k >> 2);
                tx_pos = 4'(k * 9);
                tx_neg = ~tx_pos;
                tick(s == 0 ? "R7" : (s == 1 ? "R8" : "R9"));
            end
        end
        rst_n = 1'b0;
        tick("R11");
        tick("R11");
        @(posedge clk);
        #2;
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

endmodule